// File: doc/BRIEF.md
# Byte Table Lookup Unit

This block permutes bytes for a vector datapath. It holds up to four 64-bit table registers, which are loaded through a write port. On request it builds a 32-bit result from an index word. Each of the four result byte lanes has its own 8-bit index, and that index picks one byte out of the table formed by the first one to four registers. When a lane's index falls outside the active table, that lane takes the matching byte of a default word.

A caller loads the table registers first. It then pulses `lk_start` together with an index word, a default word and a table length. The registered result and a one-cycle valid strobe appear on the next rising clock edge.

Top module: `byte_lut_unit`

## Requirements
- R1: The index word carries four independent 8-bit indices. Bits 7:0 drive result bits 7:0, bits 15:8 drive result bits 15:8, bits 23:16 drive result bits 23:16, and bits 31:24 drive result bits 31:24.
- R2: An index counts as in range only when it is strictly less than the active table size in bytes.
- R3: For an in-range index, index bits 4:3 select the table register and index bits 2:0 select byte k of it. Byte k is register bits 8k+7:8k, so byte 0 is the least significant byte.
- R4: A lane whose index is out of range returns the byte in the same lane of `lk_dflt`.
- R5: `lk_len` encodes the register count minus one. The values 0, 1, 2 and 3 give tables of 8, 16, 24 and 32 bytes.
- R6: When `tw_en` is high, `tw_data` is written to the register chosen by `tw_addr`. A lookup started in the same cycle as a write sees the old contents.
- R7: `lk_valid` is high for exactly the cycle after each cycle in which `lk_start` is high. `lk_result` shows the new value from that same clock edge.
- R8: A clock edge with `rst_n` low clears all table registers, `lk_valid` and `lk_result`.
- R9: `lk_result` holds its value through cycles that have no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tw_en | input | 1 | Table register write enable |
| tw_addr | input | 2 | Table register to write |
| tw_data | input | 64 | Table register write data |
| lk_start | input | 1 | Capture a lookup request |
| lk_index | input | 32 | Four 8-bit byte indices |
| lk_dflt | input | 32 | Default bytes for lanes whose index is out of range |
| lk_len | input | 2 | Table register count minus one |
| lk_result | output | 32 | Registered lookup result |
| lk_valid | output | 1 | One-cycle strobe for a new result |

## Verification
Both results are due one clock edge after the start cycle: the lookup word and its valid strobe. A write has a one-edge effect, so it is visible only to lookups that start in a later cycle. The bench drives inputs on falling edges. It pulses the start for one cycle and samples result and valid on the falling edge that follows the capturing rising edge. One cycle later it samples again to confirm that the strobe has dropped and the word has held. The index sweep covers all 256 values in every lane for each of the four table lengths.

// File: rtl/byte_lut_pkg.sv
// Package: shared sizes and types for the byte table lookup unit.
// Assumes byte-wide lanes and 64-bit table registers.
package byte_lut_pkg;
    localparam int BYTE_W = 8;
    localparam int TREG_W = 64;
    localparam int BYTES_PER_TREG = TREG_W / BYTE_W;
    typedef logic [BYTE_W-1:0] lut_byte_t;
endpackage

// File: rtl/byte_lut_table.sv
// Table register file: NUM_REGS registers of TREG_W bits, written one at a
// time and read out flat (register 0 in the low bits) for the lane muxes.
// Assumes a synchronous active-low reset. A read in the write cycle sees old data.
module byte_lut_table
    import byte_lut_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [TREG_W-1:0]          wr_data,
    output logic [NUM_REGS*TREG_W-1:0] tbl_flat
);
    logic [TREG_W-1:0] treg_q [NUM_REGS];

    // Clear on reset, otherwise write the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) treg_q[r] <= '0;
        end else if (wr_en) begin
            treg_q[wr_addr] <= wr_data;
        end
    end

    // Flatten the registers for the lane selectors.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign tbl_flat[g*TREG_W +: TREG_W] = treg_q[g];
    end

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_flat[$past(wr_addr)*TREG_W +: TREG_W] == $past(wr_data));
    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> tbl_flat == '0);
endmodule

// File: rtl/byte_lut_lane.sv
// One result lane: range-checks its index against the table size and picks
// either the addressed table byte or its default byte. Purely combinational.
// Assumes the index is wide enough to address every table byte.
module byte_lut_lane
    import byte_lut_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int TBL_BYTES = NUM_REGS * BYTES_PER_TREG,
    localparam int SEL_W = $clog2(TBL_BYTES),
    localparam int SZ_W = SEL_W + 1
) (
    input  lut_byte_t                  idx,
    input  lut_byte_t                  dflt,
    input  logic [SZ_W-1:0]            size_bytes,
    input  logic [NUM_REGS*TREG_W-1:0] tbl_flat,
    output lut_byte_t                  lane_out
);
    logic      in_rng;
    lut_byte_t tbl_byte;

    // Index bits above the byte offset pick the register; the low bits pick the byte.
    always_comb begin
        in_rng   = idx < BYTE_W'(size_bytes);
        tbl_byte = tbl_flat[{idx[SEL_W-1:0], 3'b000} +: BYTE_W];
        lane_out = in_rng ? tbl_byte : dflt;
    end
endmodule

// File: rtl/byte_lut_unit.sv
// Byte table lookup unit top. Holds the table registers, turns the length
// code into a byte size, runs four lane selectors and registers the result
// with a valid strobe. Assumes a synchronous active-low reset and a start
// that may be held or pulsed.
module byte_lut_unit
    import byte_lut_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int LANES = 4,
    localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TBL_BYTES = NUM_REGS * BYTES_PER_TREG,
    localparam int SZ_W = $clog2(TBL_BYTES) + 1,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tw_en,
    input  logic [ADDR_W-1:0] tw_addr,
    input  logic [TREG_W-1:0] tw_data,
    input  logic              lk_start,
    input  logic [WORD_W-1:0] lk_index,
    input  logic [WORD_W-1:0] lk_dflt,
    input  logic [ADDR_W-1:0] lk_len,
    output logic [WORD_W-1:0] lk_result,
    output logic              lk_valid
);
    logic [NUM_REGS*TREG_W-1:0] tbl_flat;
    logic [SZ_W-1:0]            size_bytes;
    logic [WORD_W-1:0]          perm_word;

    byte_lut_table #(.NUM_REGS(NUM_REGS)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tw_en), .wr_addr(tw_addr),
        .wr_data(tw_data), .tbl_flat(tbl_flat)
    );

    // Table size in bytes is eight times the register count (length code plus one).
    always_comb size_bytes = (SZ_W'(lk_len) + SZ_W'(1)) << 3;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        byte_lut_lane #(.NUM_REGS(NUM_REGS)) u_lane (
            .idx(lk_index[l*BYTE_W +: BYTE_W]),
            .dflt(lk_dflt[l*BYTE_W +: BYTE_W]),
            .size_bytes(size_bytes),
            .tbl_flat(tbl_flat),
            .lane_out(perm_word[l*BYTE_W +: BYTE_W])
        );

        // R4
        dflt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_start && (lk_index[l*BYTE_W +: BYTE_W] >= BYTE_W'(size_bytes)))
            |=> lk_result[l*BYTE_W +: BYTE_W] == $past(lk_dflt[l*BYTE_W +: BYTE_W]));
    end

    // Capture the permuted word on start and strobe valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_result <= '0;
            lk_valid  <= 1'b0;
        end else begin
            lk_valid <= lk_start;
            if (lk_start) lk_result <= perm_word;
        end
    end

    // R7
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_start |=> lk_valid);
    // R7
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_start |=> !lk_valid);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_start |=> $stable(lk_result));
endmodule

// File: tb/byte_lut_unit_tb.sv
module byte_lut_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tw_en = 1'b0;
    logic [1:0]  tw_addr = '0;
    logic [63:0] tw_data = '0;
    logic        lk_start = 1'b0;
    logic [31:0] lk_index = '0;
    logic [31:0] lk_dflt = '0;
    logic [1:0]  lk_len = '0;
    logic [31:0] lk_result;
    logic        lk_valid;

    int n_tests = 0;
    int n_fail = 0;
    int seed_cur = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_lut_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_addr(tw_addr),
        .tw_data(tw_data), .lk_start(lk_start), .lk_index(lk_index),
        .lk_dflt(lk_dflt), .lk_len(lk_len), .lk_result(lk_result),
        .lk_valid(lk_valid)
    );

    function automatic logic [7:0] tbyte(int n, int seed);
        return 8'((n * 37 + seed) & 255);
    endfunction

    function automatic logic [63:0] tregval(int r, int seed);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = tbyte(r * 8 + k, seed);
        return v;
    endfunction

    function automatic logic [31:0] model(logic [31:0] idx, logic [31:0] dflt, int len, int seed);
        logic [31:0] v;
        for (int l = 0; l < 4; l++) begin
            int ix;
            ix = int'(idx[l*8 +: 8]);
            v[l*8 +: 8] = (ix < (len + 1) * 8) ? tbyte(ix, seed) : dflt[l*8 +: 8];
        end
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(int r, logic [63:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_addr = 2'(r); tw_data = d;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    // Start on a falling edge, sample after the next rising edge.
    task automatic lookup(logic [31:0] idx, logic [31:0] dflt, int len, output logic [31:0] res);
        @(negedge clk);
        lk_start = 1'b1; lk_index = idx; lk_dflt = dflt; lk_len = 2'(len);
        @(negedge clk);
        lk_start = 1'b0;
        res = lk_result;
        check("R7 valid", 32'(lk_valid), 32'd1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R8: outputs cleared during reset
        check("R8 valid", 32'(lk_valid), 32'd0);
        check("R8 result", lk_result, 32'd0);
        rst_n = 1'b1;
        // R8: table cleared, so in-range lookups read zero
        lookup(32'h1F_10_08_00, 32'hFFFF_FFFF, 3, r);
        check("R8 table", r, 32'd0);

        for (int pass = 0; pass < 2; pass++) begin
            seed_cur = (pass == 0) ? 11 : 200;
            for (int rg = 0; rg < 4; rg++) write_reg(rg, tregval(rg, seed_cur));
            for (int len = 0; len < 4; len++) begin
                for (int i = 0; i < 256; i++) begin
                    logic [31:0] idx, dfl;
                    idx = {8'(i + 7), 8'(255 - i), 8'(i ^ 8'h55), 8'(i)};
                    dfl = {8'(i * 3), 8'hC3, 8'(i + 100), 8'h5A} ^ 32'(pass * 32'h0101_0101);
                    lookup(idx, dfl, len, r);
                    // R1 R2 R3 R4 R5: lane positions, range, addressing, default, length
                    check("R1/R2/R3/R4/R5 lookup", r, model(idx, dfl, len, seed_cur));
                end
            end
        end

        // R2/R5 boundary: index equal to size is out, size-1 is in
        for (int len = 0; len < 4; len++) begin
            logic [31:0] idx;
            idx = {8'((len + 1) * 8), 8'((len + 1) * 8 - 1), 8'((len + 1) * 8), 8'((len + 1) * 8 - 1)};
            lookup(idx, 32'hA1B2C3D4, len, r);
            check("R2 boundary", r, {8'hA1, tbyte((len + 1) * 8 - 1, seed_cur), 8'hC3, tbyte((len + 1) * 8 - 1, seed_cur)});
        end

        // R6: write and lookup in the same cycle see the old contents
        @(negedge clk);
        tw_en = 1'b1; tw_addr = 2'd0; tw_data = 64'h0807060504030201;
        lk_start = 1'b1; lk_index = 32'h03_02_01_00; lk_dflt = '0; lk_len = 2'd0;
        @(negedge clk);
        tw_en = 1'b0; lk_start = 1'b0;
        check("R6 old data", lk_result, {tbyte(3, seed_cur), tbyte(2, seed_cur), tbyte(1, seed_cur), tbyte(0, seed_cur)});
        lookup(32'h07_02_01_00, 32'd0, 0, r);
        check("R6 new data", r, 32'h08030201);

        // R3: top register high byte
        write_reg(3, 64'hEE00_0000_0000_0011);
        lookup(32'h1F_18_1F_18, 32'd0, 3, r);
        check("R3 top reg", r, 32'hEE11EE11);

        // R7/R9: strobe drops and result holds without start
        held = lk_result;
        @(negedge clk);
        check("R7 single pulse", 32'(lk_valid), 32'd0);
        lk_index = 32'h00000000; lk_dflt = 32'h12345678;
        repeat (3) @(negedge clk);
        check("R9 hold", lk_result, held);
        check("R7 idle", 32'(lk_valid), 32'd0);

        // R7: back-to-back starts
        @(negedge clk);
        lk_start = 1'b1; lk_index = 32'hFFFFFFFF; lk_dflt = 32'hCAFEF00D; lk_len = 2'd3;
        @(negedge clk);
        check("R7 b2b first", lk_result, 32'hCAFEF00D);
        lk_dflt = 32'h0BADBEEF;
        @(negedge clk);
        lk_start = 1'b0;
        check("R7 b2b second", lk_result, 32'h0BADBEEF);
        check("R7 b2b valid", 32'(lk_valid), 32'd1);

        // R8: reset mid-run clears outputs and table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R8 re-reset result", lk_result, 32'd0);
        lookup(32'h18_10_08_00, 32'd0, 3, r);
        check("R8 re-reset table", r, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule